// File: doc/BRIEF.md
# SDRAM Auto-Precharge Command Sequencer

This block turns single access requests into command sequences for a four-bank SDR SDRAM. Each request names a bank, a row, a column and a direction. The block opens the row with ACTIVE, and in the following cycle issues a READ or WRITE with auto precharge. Bursts are four beats and the CAS latency is three clocks. An access to one bank may cut short a burst that is still running on another bank. The interrupted bank then begins its internal precharge in the same cycle as the interrupting command.

A per-bank timer follows each bank through five phases: opened, bursting, write-back, precharging and idle. A bank is reported idle only after write recovery (tWR) and precharge (tRP) have run out. A request to a bank that is not idle is held off, and NOP is driven until that bank reports idle. When a WRITE follows a READ whose data is still due on the bus, the block raises DQM for two cycles before the WRITE so that late read data cannot collide with write data. Strobes mark the cycles in which read data is on the bus and the cycles in which write data must be driven.

Top module: `sdram_ap_seq`

## Requirements
- R1: Command codes on sd_cmd, written {RAS#,CAS#,WE#}, are NOP=111, ACTIVE=011, READ=101 and WRITE=100. NOP is driven in every cycle without a granted command. Out of reset, the outputs are NOP, DQM low, both strobes low and all bank_idle bits set.
- R2: A request to an idle bank gives ACTIVE with the row on sd_addr and the bank on sd_ba in the cycle after it is seen. The access follows with the column in the low sd_addr bits and sd_addr bit 10 set, and req_done is high in the access cycle only.
- R3: A READ issued in cycle t puts read beats on rd_beat in cycles t+3 through t+6.
- R4: A bank read without interruption reports idle from cycle t+7: four burst cycles, then tRP=3 precharge cycles.
- R5: A READ to another bank issued in cycle i cuts a running read burst. The first bank's beats stop at i+3, the new beats follow in i+3..i+6 with no gap, and the first bank is idle from i+tRP.
- R6: A WRITE issued while read beats are still due is preceded by exactly two cycles of DQM high with NOP. The WRITE itself has DQM low. No read beat appears in or after the WRITE cycle. wr_beat is high for the four cycles starting at the WRITE.
- R7: A WRITE with no read beats pending follows its ACTIVE in the next cycle, and DQM stays low.
- R8: A bank written without interruption is idle from w+9: four burst cycles, tWR=2 and tRP=3.
- R9: A request to a non-idle bank gets only NOP until the bank reports idle. ACTIVE comes in the cycle after bank_idle rises, and the access one cycle later.
- R10: A READ to another bank issued in cycle i cuts a running write burst. wr_beat drops at i, and the written bank passes through tWR and then tRP, so it is idle from i+5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present, held until req_done |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ADDR_W | Row to open |
| req_col | input | COL_W | Start column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_done | output | 1 | High in the cycle the access command is on sd_cmd |
| sd_cmd | output | 3 | {RAS#,CAS#,WE#} command |
| sd_addr | output | ADDR_W | Row or column address, bit AP_BIT = auto precharge |
| sd_ba | output | BANK_W | Bank address |
| sd_dqm | output | DQM_W | Byte masks, all bits equal |
| rd_beat | output | 1 | Read data beat on the bus this cycle |
| wr_beat | output | 1 | Write data must be driven this cycle |
| bank_idle | output | 2**BANK_W | Per-bank idle flag |

## Verification
The bench builds the block with its default values: CAS latency 3, burst length 4, tRP 3 and tWR 2. With these values, a precharge that starts on an interrupt ends at a different cycle from one that waits out the whole burst, whether it follows a read or a write. The DQM window and the read-beat cut-off for a WRITE that follows a READ fall inside the same short run of cycles. Short bursts and short timings keep every interrupt case and every hold-off a few tens of cycles long, so each output can be checked cycle by cycle.

// File: rtl/sdram_ap_seq_pkg.sv
package sdram_ap_seq_pkg;

  typedef enum logic [2:0] {
    CMD_ACT   = 3'b011,
    CMD_READ  = 3'b101,
    CMD_WRITE = 3'b100,
    CMD_NOP   = 3'b111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE,
    BK_OPEN,
    BK_BURST,
    BK_WRBACK,
    BK_PRECH
  } bank_phase_e;

  typedef enum logic [1:0] {
    SQ_WAIT,
    SQ_OPENED,
    SQ_MASK1,
    SQ_MASK2
  } seq_state_e;

endpackage

// File: rtl/sas_bank_timer.sv
module sas_bank_timer
  import sdram_ap_seq_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic open_i,
  input  logic access_i,
  input  logic other_access_i,
  input  logic write_i,
  output logic idle_o
);
  localparam int MAXC  = (BURST_LEN > T_RP) ? ((BURST_LEN > T_WR) ? BURST_LEN : T_WR)
                                            : ((T_RP > T_WR) ? T_RP : T_WR);
  localparam int CNT_W = $clog2(MAXC + 1);

  bank_phase_e      phase;
  logic [CNT_W-1:0] cnt;
  logic             was_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= BK_IDLE;
      cnt       <= '0;
      was_write <= 1'b0;
    end else if (open_i) begin
      phase <= BK_OPEN;
    end else if (access_i) begin
      phase     <= BK_BURST;
      cnt       <= CNT_W'(BURST_LEN - 1);
      was_write <= write_i;
    end else if (other_access_i && phase == BK_BURST) begin
      // burst cut short: recovery or precharge begins with the interrupting command
      if (was_write) begin
        phase <= BK_WRBACK;
        cnt   <= CNT_W'(T_WR - 1);
      end else begin
        phase <= BK_PRECH;
        cnt   <= CNT_W'(T_RP - 1);
      end
    end else begin
      case (phase)
        BK_BURST: begin
          if (cnt == '0) begin
            if (was_write) begin
              phase <= BK_WRBACK;
              cnt   <= CNT_W'(T_WR - 1);
            end else begin
              phase <= BK_PRECH;
              cnt   <= CNT_W'(T_RP - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BK_WRBACK: begin
          if (cnt == '0) begin
            phase <= BK_PRECH;
            cnt   <= CNT_W'(T_RP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BK_PRECH: begin
          if (cnt == '0) phase <= BK_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: phase <= phase;
      endcase
    end
  end

  assign idle_o = (phase == BK_IDLE);

endmodule

// File: rtl/sas_beat_pipe.sv
module sas_beat_pipe #(
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic issue_rd_i,
  input  logic issue_wr_i,
  output logic rd_beat_o,
  output logic wr_beat_o,
  output logic rd_pending_o
);
  localparam int SH_LEN = CAS_LAT + BURST_LEN;
  localparam int WC_W   = $clog2(BURST_LEN + 1);

  // bit k set: a read beat will be on the bus k cycles from now
  logic [SH_LEN-1:0] beats, beats_nx;
  logic [WC_W-1:0]   wr_left;

  always_comb begin
    beats_nx = beats >> 1;
    if (issue_wr_i) begin
      beats_nx = '0;
    end else if (issue_rd_i) begin
      for (int k = CAS_LAT; k < SH_LEN; k++) beats_nx[k] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beats   <= '0;
      wr_left <= '0;
    end else begin
      beats <= beats_nx;
      if (issue_wr_i)        wr_left <= WC_W'(BURST_LEN);
      else if (issue_rd_i)   wr_left <= '0;
      else if (wr_left != 0) wr_left <= wr_left - 1'b1;
    end
  end

  assign rd_beat_o    = beats[0];
  assign wr_beat_o    = (wr_left != '0);
  assign rd_pending_o = |beats[SH_LEN-1:1];

endmodule

// File: rtl/sas_issue_fsm.sv
module sas_issue_fsm
  import sdram_ap_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10,
  parameter int DQM_W  = 4,
  localparam int NB    = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  input  logic [NB-1:0]     bank_idle,
  input  logic              rd_pending,
  output logic              nx_open,
  output logic              nx_access,
  output logic              nx_write,
  output logic [BANK_W-1:0] nx_bank,
  output logic [2:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              done_o
);
  seq_state_e        st, st_nx;
  logic [BANK_W-1:0] lat_bank;
  logic [COL_W-1:0]  lat_col;
  logic              lat_wr;
  logic              go_acc;
  sd_cmd_e           cmd_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic              dqm_nx;

  always_comb begin
    st_nx     = st;
    nx_open   = 1'b0;
    nx_access = 1'b0;
    nx_write  = lat_wr;
    nx_bank   = lat_bank;
    go_acc    = 1'b0;
    cmd_nx    = CMD_NOP;
    addr_nx   = addr_o;
    dqm_nx    = 1'b0;
    case (st)
      SQ_WAIT: begin
        if (req_valid && bank_idle[req_bank]) begin
          nx_open = 1'b1;
          nx_bank = req_bank;
          cmd_nx  = CMD_ACT;
          addr_nx = req_row;
          st_nx   = SQ_OPENED;
        end
      end
      SQ_OPENED: begin
        if (lat_wr && rd_pending) begin
          dqm_nx = 1'b1;
          st_nx  = SQ_MASK1;
        end else begin
          go_acc = 1'b1;
        end
      end
      SQ_MASK1: begin
        dqm_nx = 1'b1;
        st_nx  = SQ_MASK2;
      end
      default: go_acc = 1'b1;
    endcase
    if (go_acc) begin
      nx_access              = 1'b1;
      cmd_nx                 = lat_wr ? CMD_WRITE : CMD_READ;
      addr_nx                = '0;
      addr_nx[COL_W-1:0]     = lat_col;
      addr_nx[AP_BIT]        = 1'b1;
      st_nx                  = SQ_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_WAIT;
      lat_bank <= '0;
      lat_col  <= '0;
      lat_wr   <= 1'b0;
      cmd_o    <= CMD_NOP;
      addr_o   <= '0;
      ba_o     <= '0;
      dqm_o    <= '0;
      done_o   <= 1'b0;
    end else begin
      st     <= st_nx;
      cmd_o  <= cmd_nx;
      addr_o <= addr_nx;
      dqm_o  <= {DQM_W{dqm_nx}};
      done_o <= go_acc;
      if (nx_open) begin
        lat_bank <= req_bank;
        lat_col  <= req_col;
        lat_wr   <= req_write;
        ba_o     <= req_bank;
      end
    end
  end

endmodule

// File: rtl/sdram_ap_seq.sv
module sdram_ap_seq #(
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = 13,
  parameter int COL_W     = 9,
  parameter int AP_BIT    = 10,
  parameter int DQM_W     = 4,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  localparam int NB       = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  output logic              req_done,
  output logic [2:0]        sd_cmd,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              rd_beat,
  output logic              wr_beat,
  output logic [NB-1:0]     bank_idle
);
  logic              nx_open, nx_access, nx_write, rd_pending;
  logic [BANK_W-1:0] nx_bank;

  sas_issue_fsm #(
    .BANK_W(BANK_W), .ADDR_W(ADDR_W), .COL_W(COL_W),
    .AP_BIT(AP_BIT), .DQM_W(DQM_W)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_write(req_write),
    .bank_idle(bank_idle), .rd_pending(rd_pending),
    .nx_open(nx_open), .nx_access(nx_access), .nx_write(nx_write), .nx_bank(nx_bank),
    .cmd_o(sd_cmd), .addr_o(sd_addr), .ba_o(sd_ba), .dqm_o(sd_dqm), .done_o(req_done)
  );

  sas_beat_pipe #(.CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)) u_beats (
    .clk(clk), .rst(rst),
    .issue_rd_i(nx_access && !nx_write),
    .issue_wr_i(nx_access && nx_write),
    .rd_beat_o(rd_beat), .wr_beat_o(wr_beat), .rd_pending_o(rd_pending)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sas_bank_timer #(.BURST_LEN(BURST_LEN), .T_RP(T_RP), .T_WR(T_WR)) u_timer (
      .clk(clk), .rst(rst),
      .open_i(nx_open && nx_bank == BANK_W'(b)),
      .access_i(nx_access && nx_bank == BANK_W'(b)),
      .other_access_i(nx_access && nx_bank != BANK_W'(b)),
      .write_i(nx_write),
      .idle_o(bank_idle[b])
    );
  end

endmodule

// File: rtl/sdram_ap_seq_chk.sv
module sdram_ap_seq_chk #(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9,
  parameter int DQM_W  = 4,
  localparam int NB    = 1 << BANK_W
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [BANK_W-1:0] req_bank,
  input logic [ADDR_W-1:0] req_row,
  input logic [COL_W-1:0]  req_col,
  input logic              req_write,
  input logic              req_done,
  input logic [2:0]        sd_cmd,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BANK_W-1:0] sd_ba,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic              rd_beat,
  input logic              wr_beat,
  input logic [NB-1:0]     bank_idle
);
  logic [NB-1:0] idle_q;
  always_ff @(posedge clk) idle_q <= bank_idle;

  p_cmd_legal_r1: assert property (@(posedge clk) disable iff (rst)
    sd_cmd == 3'b111 || sd_cmd == 3'b011 || sd_cmd == 3'b101 || sd_cmd == 3'b100);

  p_done_on_access_r2: assert property (@(posedge clk) disable iff (rst)
    req_done |-> (sd_cmd == 3'b101 || sd_cmd == 3'b100));

  p_act_then_access_r2: assert property (@(posedge clk) disable iff (rst)
    sd_cmd == 3'b011 |=> (sd_cmd == 3'b101 || sd_cmd == 3'b100 || sd_dqm != '0));

  p_access_bank_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (sd_cmd == 3'b101 || sd_cmd == 3'b100) |-> !bank_idle[sd_ba]);

  p_write_unmasked_r6: assert property (@(posedge clk) disable iff (rst)
    sd_cmd == 3'b100 |-> sd_dqm == '0);

  p_mask_two_cycles_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_dqm[0]) |=> sd_dqm[0]);

  p_mask_with_nop_r6: assert property (@(posedge clk) disable iff (rst)
    sd_dqm != '0 |-> sd_cmd == 3'b111);

  p_no_bus_clash_r6: assert property (@(posedge clk) disable iff (rst)
    !(rd_beat && wr_beat));

  p_act_needs_idle_r9: assert property (@(posedge clk) disable iff (rst)
    sd_cmd == 3'b011 |-> idle_q[sd_ba]);

endmodule

bind sdram_ap_seq sdram_ap_seq_chk #(
  .BANK_W(BANK_W), .ADDR_W(ADDR_W), .COL_W(COL_W), .DQM_W(DQM_W)
) u_chk (.*);

// File: tb/test_sdram_ap_seq.sv
`timescale 1ns/1ps
module test_sdram_ap_seq;
  localparam int BANK_W = 2;
  localparam int ADDR_W = 13;
  localparam int COL_W  = 9;
  localparam int DQM_W  = 4;
  localparam int NOP = 7, ACT = 3, RD = 5, WR = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ADDR_W-1:0] req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic              req_write = 1'b0;
  logic              req_done;
  logic [2:0]        sd_cmd;
  logic [ADDR_W-1:0] sd_addr;
  logic [BANK_W-1:0] sd_ba;
  logic [DQM_W-1:0]  sd_dqm;
  logic              rd_beat, wr_beat;
  logic [3:0]        bank_idle;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  sdram_ap_seq i_sdram_ap_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_write(req_write),
    .req_done(req_done), .sd_cmd(sd_cmd), .sd_addr(sd_addr), .sd_ba(sd_ba),
    .sd_dqm(sd_dqm), .rd_beat(rd_beat), .wr_beat(wr_beat), .bank_idle(bank_idle)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_req(input int b, input int row, input int col, input bit wr);
    req_valid = 1'b1;
    req_bank  = BANK_W'(b);
    req_row   = ADDR_W'(row);
    req_col   = COL_W'(col);
    req_write = wr;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 40 && bank_idle != 4'hF; n++) @(negedge clk);
  endtask

  task automatic do_access(input int b, input bit wr);
    start_req(b, 'h10 + b, 'h20 + b, wr);
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      if (req_done) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset cmd", int'(sd_cmd), NOP);
    check("R1 reset dqm", int'(sd_dqm), 0);
    check("R1 reset strobes", int'({rd_beat, wr_beat}), 0);
    check("R1 reset idle", int'(bank_idle), 15);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset cmd", int'(sd_cmd), NOP);
  endtask

  task automatic t_read_single();
    wait_idle();
    start_req(0, 'h123, 'h45, 1'b0);
    @(negedge clk);
    check("R2 active cmd", int'(sd_cmd), ACT);
    check("R2 active row", int'(sd_addr), 'h123);
    check("R2 active bank", int'(sd_ba), 0);
    @(negedge clk);
    check("R2 read cmd", int'(sd_cmd), RD);
    check("R2 read col+ap", int'(sd_addr), 'h45 | (1 << 10));
    check("R2 done", int'(req_done), 1);
    req_valid = 1'b0;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      check($sformatf("R3 rd_beat k=%0d", k), int'(rd_beat), int'(k >= 3 && k <= 6));
      check($sformatf("R4 bank0 idle k=%0d", k), int'(bank_idle[0]), int'(k >= 7));
      check($sformatf("R1 nop k=%0d", k), int'(sd_cmd), NOP);
      check($sformatf("R2 done low k=%0d", k), int'(req_done), 0);
    end
  endtask

  task automatic t_read_interrupt();
    wait_idle();
    do_access(1, 1'b0);
    start_req(2, 'h55, 'h12, 1'b0);
    for (int k = 1; k <= 11; k++) begin
      @(negedge clk);
      if (req_done) begin
        check("R5 interrupt read issued k", k, 2);
        req_valid = 1'b0;
      end
      check($sformatf("R5 cmd k=%0d", k), int'(sd_cmd), k == 1 ? ACT : (k == 2 ? RD : NOP));
      check($sformatf("R5 rd_beat k=%0d", k), int'(rd_beat), int'(k >= 3 && k <= 8));
      check($sformatf("R5 bank1 idle k=%0d", k), int'(bank_idle[1]), int'(k >= 5));
      check($sformatf("R4 bank2 idle k=%0d", k), int'(bank_idle[2]), int'(k >= 9));
    end
  endtask

  task automatic t_write_interrupt();
    wait_idle();
    do_access(0, 1'b0);
    start_req(3, 'h77, 'h33, 1'b1);
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      if (req_done) req_valid = 1'b0;
      check($sformatf("R6 cmd k=%0d", k), int'(sd_cmd), k == 1 ? ACT : (k == 4 ? WR : NOP));
      check($sformatf("R6 dqm k=%0d", k), int'(sd_dqm), (k == 2 || k == 3) ? 15 : 0);
      check($sformatf("R6 rd_beat k=%0d", k), int'(rd_beat), int'(k == 3));
      check($sformatf("R6 wr_beat k=%0d", k), int'(wr_beat), int'(k >= 4 && k <= 7));
      check($sformatf("R8 bank3 idle k=%0d", k), int'(bank_idle[3]), int'(k >= 13));
    end
  endtask

  task automatic t_write_plain();
    wait_idle();
    start_req(2, 'h99, 'h7, 1'b1);
    @(negedge clk);
    check("R7 active cmd", int'(sd_cmd), ACT);
    check("R7 dqm at active", int'(sd_dqm), 0);
    @(negedge clk);
    check("R7 write next cycle", int'(sd_cmd), WR);
    check("R7 write done", int'(req_done), 1);
    req_valid = 1'b0;
    for (int k = 0; k <= 10; k++) begin
      if (k > 0) @(negedge clk);
      check($sformatf("R7 dqm k=%0d", k), int'(sd_dqm), 0);
      check($sformatf("R6 wr_beat k=%0d", k), int'(wr_beat), int'(k <= 3));
      check($sformatf("R8 bank2 idle k=%0d", k), int'(bank_idle[2]), int'(k >= 9));
    end
  endtask

  task automatic t_hold_off();
    wait_idle();
    do_access(1, 1'b0);
    start_req(1, 'h44, 'h9, 1'b0);
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      check($sformatf("R9 cmd k=%0d", k), int'(sd_cmd), k == 8 ? ACT : (k == 9 ? RD : NOP));
      check($sformatf("R9 done k=%0d", k), int'(req_done), int'(k == 9));
      check($sformatf("R9 bank1 idle k=%0d", k), int'(bank_idle[1]), int'(k == 7));
      if (req_done) req_valid = 1'b0;
    end
  endtask

  task automatic t_write_cut();
    wait_idle();
    do_access(0, 1'b1);
    start_req(1, 'h66, 'h3, 1'b0);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (req_done) req_valid = 1'b0;
      check($sformatf("R10 cmd k=%0d", k), int'(sd_cmd), k == 1 ? ACT : (k == 2 ? RD : NOP));
      check($sformatf("R10 wr_beat k=%0d", k), int'(wr_beat), int'(k == 1));
      check($sformatf("R10 bank0 idle k=%0d", k), int'(bank_idle[0]), int'(k >= 7));
      check($sformatf("R3 rd_beat k=%0d", k), int'(rd_beat), int'(k >= 5 && k <= 8));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_read_single();
    t_read_interrupt();
    t_write_interrupt();
    t_write_plain();
    t_hold_off();
    t_write_cut();
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule